// File: doc/BRIEF.md
# Filter Output Scaler with Selectable Rounding

This block is the last stage of a filter datapath. It takes the full-precision result of the filter, `IN_W` bits wide, and turns it into a narrower `OUT_W`-bit word held in an output register. The upper `OUT_W` bits are kept and the `IN_W-OUT_W` lower bits are dropped. A one-bit mode input, sampled with each valid word, chooses how the dropped bits are handled. Truncation simply discards them, which moves the value toward minus infinity. Round-to-nearest adds half an output step before discarding them.

The parameter `IS_SIGNED` sets whether the word is read as two's complement or as unsigned. This affects only the largest value the output can hold. When rounding up would go past that value, the output saturates instead of wrapping. The result appears one clock after its input, together with a valid strobe. Between valid words the output register holds its last value.

Top module: `fir_out_scaler`

## Requirements
- R1: While `rst` is high at a clock edge, `out_vld` and `out_data` become 0 at that edge.
- R2: `out_vld` is high in the clock cycle after each cycle in which `in_vld` is high, and low after each cycle in which `in_vld` is low.
- R3: With `in_mode` = 0 (truncate), `out_data` equals bits `[IN_W-1:IN_W-OUT_W]` of the accepted `in_data`. This is the floor of the value divided by 2^(IN_W-OUT_W) (for 8 to 6 bits: 0xA9 gives 42 unsigned and -22 signed, and 0xAB gives 42 and -22).
- R4: With `in_mode` = 1 (nearest), the kept bits are incremented when bit `IN_W-OUT_W-1` of `in_data` is 1. An exact half therefore rounds toward plus infinity (for 8 to 6 bits: 0xAB gives 43 unsigned and -21 signed, 0xAA gives 43 and -21, and 0xA9 gives 42 and -22).
- R5: In nearest mode, an increment that would pass the largest output value leaves the output at that value. The largest value is all ones when unsigned, and 0 followed by ones when signed (for 8 to 6 bits: 0xFE unsigned gives 63, and 0x7E signed gives 31).
- R6: With `IS_SIGNED` = 1, negative inputs give correctly rounded negative outputs with no special case at the sign boundary (for 8 to 6 bits: 0xFF in nearest mode gives 0, and 0x80 gives -32 in both modes).
- R7: A cycle with `in_vld` low leaves `out_data` unchanged, whatever `in_data` and `in_mode` carry.
- R8: `in_mode` is sampled on the same edge as its `in_data`. Back-to-back words with different modes each use their own mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Marks a full-precision word on `in_data` |
| in_mode | input | 1 | 0 = truncate, 1 = round to nearest |
| in_data | input | IN_W | Full-precision filter result |
| out_vld | output | 1 | Registered valid, one clock after `in_vld` |
| out_data | output | OUT_W | Registered scaled result |

## Verification
The hardest situation to reach is saturation. It needs nearest mode, a half bit of 1, and kept bits already at the maximum. That maximum is a different code for signed and for unsigned readings, so one input pattern covers only one of the two. The bench drives the two saturating codes directly to a signed instance and an unsigned instance that share their inputs. It then sweeps every 8-bit code in both modes against an arithmetic model (add half, floor-shift, clamp), which also covers the ties and the sign-boundary codes.

// File: rtl/fir_scl_pkg.sv
package fir_scl_pkg;
  typedef enum logic {
    SCL_TRUNC   = 1'b0,
    SCL_NEAREST = 1'b1
  } scl_mode_e;
endpackage

// File: rtl/fir_scl_split.sv
// Splits the full-precision word into the kept upper bits and the
// highest discarded bit (worth half an output step).
module fir_scl_split #(
  parameter int IN_W  = 8,
  parameter int OUT_W = 6
) (
  input  logic [IN_W-1:0]  full_i,
  output logic [OUT_W-1:0] kept_o,
  output logic             half_o
);
  localparam int DROP_W = IN_W - OUT_W;

  logic unused_tail;
  assign unused_tail = ^full_i;

  assign kept_o = full_i[IN_W-1:DROP_W];

  generate
    if (DROP_W > 0) begin : g_drop
      assign half_o = full_i[DROP_W-1];
    end else begin : g_pass
      assign half_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/fir_scl_round.sv
// Applies the rounding increment and clamps at the largest output code.
module fir_scl_round #(
  parameter int OUT_W     = 6,
  parameter bit IS_SIGNED = 1'b1
) (
  input  logic [OUT_W-1:0] kept_i,
  input  logic             half_i,
  input  logic             nearest_i,
  output logic [OUT_W-1:0] res_o
);
  localparam logic [OUT_W-1:0] MAX_CODE =
    IS_SIGNED ? {1'b0, {(OUT_W-1){1'b1}}} : {OUT_W{1'b1}};

  logic bump;
  logic at_max;

  always_comb begin
    bump   = nearest_i & half_i;
    at_max = (kept_i == MAX_CODE);
    if (bump && !at_max) res_o = kept_i + OUT_W'(1);
    else                 res_o = kept_i;
  end
endmodule

// File: rtl/fir_out_scaler.sv
module fir_out_scaler
  import fir_scl_pkg::*;
#(
  parameter int IN_W      = 8,
  parameter int OUT_W     = 6,
  parameter bit IS_SIGNED = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_vld,
  input  logic             in_mode,
  input  logic [IN_W-1:0]  in_data,
  output logic             out_vld,
  output logic [OUT_W-1:0] out_data
);
  logic [OUT_W-1:0] kept;
  logic             half;
  logic             nearest;
  logic [OUT_W-1:0] scaled;

  assign nearest = (scl_mode_e'(in_mode) == SCL_NEAREST);

  fir_scl_split #(.IN_W(IN_W), .OUT_W(OUT_W)) split_i (
    .full_i (in_data),
    .kept_o (kept),
    .half_o (half)
  );

  fir_scl_round #(.OUT_W(OUT_W), .IS_SIGNED(IS_SIGNED)) round_i (
    .kept_i    (kept),
    .half_i    (half),
    .nearest_i (nearest),
    .res_o     (scaled)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld  <= 1'b0;
      out_data <= '0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) out_data <= scaled;
    end
  end
endmodule

// File: rtl/fir_out_scaler_chk.sv
module fir_out_scaler_chk #(
  parameter int IN_W      = 8,
  parameter int OUT_W     = 6,
  parameter bit IS_SIGNED = 1'b1
) (
  input logic             clk,
  input logic             rst,
  input logic             in_vld,
  input logic             in_mode,
  input logic [IN_W-1:0]  in_data,
  input logic             out_vld,
  input logic [OUT_W-1:0] out_data
);
  localparam int DROP_W = IN_W - OUT_W;
  localparam logic [OUT_W-1:0] TOP =
    IS_SIGNED ? {1'b0, {(OUT_W-1){1'b1}}} : {OUT_W{1'b1}};

  logic [OUT_W-1:0] floor_w;
  logic [OUT_W-1:0] floor_up_w;
  logic             unused_chk;
  assign floor_w    = in_data[IN_W-1:DROP_W];
  assign floor_up_w = floor_w + OUT_W'(1);
  assign unused_chk = ^in_data;

  a_r2_vld_rise: assert property (@(posedge clk) disable iff (rst)
    (!rst && in_vld) |=> out_vld);

  a_r2_vld_idle: assert property (@(posedge clk) disable iff (rst)
    (!rst && !in_vld) |=> !out_vld);

  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (!rst && !in_vld) |=> $stable(out_data));

  a_r3_trunc_floor: assert property (@(posedge clk) disable iff (rst)
    (!rst && in_vld && !in_mode) |=> out_data == $past(floor_w));

  a_r4_near_step: assert property (@(posedge clk) disable iff (rst)
    (!rst && in_vld && in_mode) |=>
      (out_data == $past(floor_w) || out_data == $past(floor_up_w)));

  generate
    if (DROP_W > 0) begin : g_sat
      a_r5_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (!rst && in_vld && in_mode && in_data[DROP_W-1] && floor_w == TOP)
          |=> out_data == TOP);
    end
  endgenerate
endmodule

bind fir_out_scaler fir_out_scaler_chk #(
  .IN_W(IN_W), .OUT_W(OUT_W), .IS_SIGNED(IS_SIGNED)
) chk_i (
  .clk(clk), .rst(rst), .in_vld(in_vld), .in_mode(in_mode),
  .in_data(in_data), .out_vld(out_vld), .out_data(out_data)
);

// File: tb/fir_out_scaler_tb_top.sv
module fir_out_scaler_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_vld = 1'b0;
  logic       in_mode = 1'b0;
  logic [7:0] in_data = '0;
  logic       vld_s, vld_u;
  logic [5:0] dat_s, dat_u;
  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  fir_out_scaler #(.IN_W(8), .OUT_W(6), .IS_SIGNED(1'b1)) dut_i (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_mode(in_mode),
    .in_data(in_data), .out_vld(vld_s), .out_data(dat_s)
  );

  fir_out_scaler #(.IN_W(8), .OUT_W(6), .IS_SIGNED(1'b0)) dut_u_i (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_mode(in_mode),
    .in_data(in_data), .out_vld(vld_u), .out_data(dat_u)
  );

  // Model: add half a step when rounding, floor-shift by 2, clamp.
  function automatic int model(bit sgn, bit near, logic [7:0] d);
    int v;
    int mx;
    v  = sgn ? int'($signed(d)) : int'(d);
    if (near) v = v + 2;
    v  = v >>> 2;
    mx = sgn ? 31 : 63;
    if (v > mx) v = mx;
    return v & 63;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic drive(bit mode, logic [7:0] d);
    @(negedge clk);
    in_vld  = 1'b1;
    in_mode = mode;
    in_data = d;
    @(negedge clk);
    in_vld  = 1'b0;
  endtask

  task automatic expect_both(string tag, bit mode, logic [7:0] d);
    drive(mode, d);
    chk({tag, " signed"},   int'(dat_s), model(1'b1, mode, d));
    chk({tag, " unsigned"}, int'(dat_u), model(1'b0, mode, d));
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 vld signed",    int'(vld_s), 0);
    chk("R1 data signed",   int'(dat_s), 0);
    chk("R1 vld unsigned",  int'(vld_u), 0);
    chk("R1 data unsigned", int'(dat_u), 0);
  endtask

  task automatic t_examples;
    drive(1'b0, 8'hA9);
    chk("R3 0xA9 trunc unsigned", int'(dat_u), 42);
    chk("R6 0xA9 trunc signed",   int'(dat_s), (-22) & 63);
    drive(1'b1, 8'hA9);
    chk("R4 0xA9 near unsigned",  int'(dat_u), 42);
    chk("R6 0xA9 near signed",    int'(dat_s), (-22) & 63);
    drive(1'b0, 8'hAB);
    chk("R3 0xAB trunc unsigned", int'(dat_u), 42);
    chk("R3 0xAB trunc signed",   int'(dat_s), (-22) & 63);
    drive(1'b1, 8'hAB);
    chk("R4 0xAB near unsigned",  int'(dat_u), 43);
    chk("R4 0xAB near signed",    int'(dat_s), (-21) & 63);
  endtask

  task automatic t_ties;
    drive(1'b1, 8'hAA);
    chk("R4 tie unsigned", int'(dat_u), 43);
    chk("R4 tie signed",   int'(dat_s), (-21) & 63);
    drive(1'b1, 8'hFF);
    chk("R6 0xFF near signed", int'(dat_s), 0);
    drive(1'b1, 8'h80);
    chk("R6 0x80 near signed", int'(dat_s), (-32) & 63);
  endtask

  task automatic t_saturate;
    drive(1'b1, 8'hFE);
    chk("R5 sat unsigned", int'(dat_u), 63);
    drive(1'b1, 8'h7E);
    chk("R5 sat signed", int'(dat_s), 31);
    drive(1'b1, 8'h7F);
    chk("R5 sat signed 0x7F", int'(dat_s), 31);
  endtask

  task automatic t_sweep;
    for (int m = 0; m < 2; m++) begin
      for (int i = 0; i < 256; i++) begin
        expect_both(m == 0 ? "R3 sweep" : "R4 sweep", bit'(m), 8'(i));
      end
    end
  endtask

  task automatic t_valid_hold;
    drive(1'b0, 8'h40);
    chk("R2 vld high after word", int'(vld_s), 1);
    @(negedge clk);
    chk("R2 vld low after idle", int'(vld_s), 0);
    in_mode = 1'b1;
    in_data = 8'hFF;
    @(negedge clk);
    @(negedge clk);
    chk("R7 hold signed",   int'(dat_s), 16);
    chk("R7 hold unsigned", int'(dat_u), 16);
    chk("R2 vld still low", int'(vld_u), 0);
  endtask

  task automatic t_mode_per_word;
    @(negedge clk);
    in_vld  = 1'b1;
    in_data = 8'hAB;
    in_mode = 1'b0;
    @(negedge clk);
    chk("R8 first word trunc", int'(dat_u), 42);
    in_mode = 1'b1;
    @(negedge clk);
    chk("R8 second word near", int'(dat_u), 43);
    chk("R8 second vld", int'(vld_u), 1);
    in_vld = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_examples();
    t_ties();
    t_saturate();
    t_valid_hold();
    t_mode_per_word();
    t_sweep();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule